// File: doc/BRIEF.md
# Accumulator ALU with decimal adjust

This block is the 8-bit arithmetic and logic unit of a small controller core. It holds an accumulator A, a helper register B and four status bits: carry, auxiliary (nibble) carry, signed overflow and parity. Each cycle the surrounding datapath may present one operation code together with an 8-bit second operand. Single-cycle operations update A and the flags at the clock edge that accepts them.

Multiply and divide work on A and B together and take several cycles. While they run the block raises a busy output and drops any new request. Each operation has its own rule for which flags it rewrites and which it keeps, so the flags seen by the next operation, such as a decimal adjust or a carry rotate, are the ones that operation expects. Decimal adjust corrects A after a binary addition of two packed BCD bytes.

Top module: `acc_alu`

## Requirements
- R1: Code 3 sets A to A + operand and code 4 sets A to A + operand + C. Both set C to the carry out of bit 7, AC to the carry out of bit 3 and OV to signed two's-complement overflow.
- R2: Code 5 sets A to A − operand − C. It sets C when the full result borrows, AC when the low nibble borrows, and OV on signed overflow.
- R3: Code 6 increments A and code 7 decrements A, both modulo 256. C, AC and OV keep their values.
- R4: Code 1 loads the operand into A and code 2 loads it into B. Codes 8, 9 and 10 put A AND, OR or XOR operand into A. Code 11 writes 0x00 to A, code 12 writes the bitwise inverse of A, and code 17 exchanges the two nibbles of A. Code 0 and codes 21 to 31 change nothing. None of these codes changes C, AC or OV.
- R5: Code 13 rotates A left and code 15 rotates A right, and neither touches C. Code 14 rotates left through carry: A7 goes to C and the old C to A0. Code 16 rotates right through carry: A0 goes to C and the old C to A7.
- R6: Code 18 (decimal adjust) first adds 6 to A when the low nibble is above 9 or AC is set. It then adds 0x60 when the resulting high nibble is above 9, C is set, or the first step carried out of bit 7. C is set if either step carries out of bit 7 and is never cleared. AC and OV are kept.
- R7: Code 19 multiplies A by B as unsigned numbers and puts product bits 7..0 in A and bits 15..8 in B. It clears C and sets OV exactly when the product exceeds 255.
- R8: Code 20 divides A by B as unsigned numbers and puts the quotient in A and the remainder in B, with C and OV cleared. When B is 0 it sets OV, clears C and leaves A and B unchanged.
- R9: After code 19 or 20 is accepted, busy_o is high for exactly 3 cycles. A and B hold until the edge at which busy_o falls, when the results appear. Requests made while busy_o is high are ignored, and AC is never changed by these two codes.
- R10: par_o always equals the XOR of the eight bits of A.
- R11: After reset A, B, C, AC and OV are zero and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request, accepted when busy_o is low |
| op_i | input | 5 | Operation code |
| operand_i | input | 8 | Second operand |
| acc_o | output | 8 | Accumulator A |
| b_o | output | 8 | Helper register B |
| cy_o | output | 1 | Carry flag |
| ac_o | output | 1 | Auxiliary (nibble) carry flag |
| ov_o | output | 1 | Overflow flag |
| par_o | output | 1 | Parity of A |
| busy_o | output | 1 | Multiply or divide in progress |

## Verification
Additions are tried with operands that carry out of bit 3 only, out of bit 7 only, and across the sign boundary, so that each flag is shown to come from its own bit position. Subtractions are tried with and without an incoming borrow and with a zero minuend, which tells a borrow into the low nibble apart from a borrow out of the whole byte. Decimal adjust is applied after BCD sums that need no correction, only the low correction, both corrections, and a correction forced by an existing carry. Multiply and divide are run with small and wrapping products, a divide with a remainder, a divide by zero, and a request injected while busy, which checks the hold and drop behaviour.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  parameter int DW   = 8;
  parameter int NW   = DW / 2;
  parameter int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,
    OP_LDA  = 5'd1,
    OP_LDB  = 5'd2,
    OP_ADD  = 5'd3,
    OP_ADDC = 5'd4,
    OP_SUBB = 5'd5,
    OP_INC  = 5'd6,
    OP_DEC  = 5'd7,
    OP_AND  = 5'd8,
    OP_OR   = 5'd9,
    OP_XOR  = 5'd10,
    OP_CLR  = 5'd11,
    OP_CPL  = 5'd12,
    OP_RL   = 5'd13,
    OP_RLC  = 5'd14,
    OP_RR   = 5'd15,
    OP_RRC  = 5'd16,
    OP_SWAP = 5'd17,
    OP_DA   = 5'd18,
    OP_MUL  = 5'd19,
    OP_DIV  = 5'd20
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          ac_o,
  output logic          ov_o
);
  logic [DW:0] full;
  logic [NW:0] low;

  always_comb begin
    if (sub_i) begin
      full = {1'b0, a_i} - {1'b0, b_i} - (DW+1)'(cin_i);
      low  = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - (NW+1)'(cin_i);
      ov_o = (a_i[DW-1] ^ b_i[DW-1]) & (full[DW-1] ^ a_i[DW-1]);
    end else begin
      full = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'(cin_i);
      low  = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + (NW+1)'(cin_i);
      ov_o = ~(a_i[DW-1] ^ b_i[DW-1]) & (full[DW-1] ^ a_i[DW-1]);
    end
    res_o = full[DW-1:0];
    c_o   = full[DW];   // carry on add, borrow on subtract
    ac_o  = low[NW];
  end
endmodule

// File: rtl/acc_alu_dadj.sv
module acc_alu_dadj
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic          c_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          c_o
);
  logic [DW:0] step_lo, step_hi;
  logic        fix_lo, fix_hi;

  always_comb begin
    fix_lo  = (a_i[NW-1:0] > NW'(9)) | ac_i;
    step_lo = {1'b0, a_i} + (fix_lo ? (DW+1)'(6) : '0);
    fix_hi  = (step_lo[DW-1:NW] > NW'(9)) | c_i | step_lo[DW];
    step_hi = {1'b0, step_lo[DW-1:0]} + (fix_hi ? ((DW+1)'(6) << NW) : '0);
    res_o   = step_hi[DW-1:0];
    c_o     = c_i | step_lo[DW] | step_hi[DW];
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] prod_lo_o,
  output logic [DW-1:0] prod_hi_o,
  output logic          prod_wide_o,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          div_zero_o
);
  logic [2*DW-1:0] prod;

  always_comb begin
    prod        = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};
    prod_lo_o   = prod[DW-1:0];
    prod_hi_o   = prod[2*DW-1:DW];
    prod_wide_o = |prod[2*DW-1:DW];
    div_zero_o  = (b_i == '0);
    quo_o       = div_zero_o ? '0 : a_i / b_i;
    rem_o       = div_zero_o ? '0 : a_i % b_i;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int MD_CYCLES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   operand_i,
  output logic [DW-1:0]   acc_o,
  output logic [DW-1:0]   b_o,
  output logic            cy_o,
  output logic            ac_o,
  output logic            ov_o,
  output logic            par_o,
  output logic            busy_o
);
  localparam int CNT_W = (MD_CYCLES > 2) ? $clog2(MD_CYCLES) : 1;

  logic [DW-1:0]    acc_q, acc_d, b_q, b_d;
  logic             cy_q, cy_d, ac_q, ac_d, ov_q, ov_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_q, div_d;
  logic             busy;
  alu_op_e          op;

  logic [DW-1:0] as_res, da_res, p_lo, p_hi, quo, rem;
  logic          as_c, as_ac, as_ov, da_c, p_wide, div_zero;

  assign busy = (cnt_q != '0);
  assign op   = alu_op_e'(op_i);

  acc_alu_addsub u_addsub (
    .a_i   (acc_q),
    .b_i   (operand_i),
    .cin_i ((op == OP_ADD) ? 1'b0 : cy_q),
    .sub_i (op == OP_SUBB),
    .res_o (as_res),
    .c_o   (as_c),
    .ac_o  (as_ac),
    .ov_o  (as_ov)
  );

  acc_alu_dadj u_dadj (
    .a_i   (acc_q),
    .c_i   (cy_q),
    .ac_i  (ac_q),
    .res_o (da_res),
    .c_o   (da_c)
  );

  acc_alu_muldiv u_muldiv (
    .a_i         (acc_q),
    .b_i         (b_q),
    .prod_lo_o   (p_lo),
    .prod_hi_o   (p_hi),
    .prod_wide_o (p_wide),
    .quo_o       (quo),
    .rem_o       (rem),
    .div_zero_o  (div_zero)
  );

  always_comb begin
    acc_d = acc_q;
    b_d   = b_q;
    cy_d  = cy_q;
    ac_d  = ac_q;
    ov_d  = ov_q;
    cnt_d = cnt_q;
    div_d = div_q;
    if (busy) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        cy_d = 1'b0;
        if (div_q) begin
          if (div_zero) begin
            ov_d = 1'b1;
          end else begin
            acc_d = quo;
            b_d   = rem;
            ov_d  = 1'b0;
          end
        end else begin
          acc_d = p_lo;
          b_d   = p_hi;
          ov_d  = p_wide;
        end
      end
    end else if (op_valid_i) begin
      case (op)
        OP_LDA:  acc_d = operand_i;
        OP_LDB:  b_d   = operand_i;
        OP_ADD, OP_ADDC, OP_SUBB: begin
          acc_d = as_res;
          cy_d  = as_c;
          ac_d  = as_ac;
          ov_d  = as_ov;
        end
        OP_INC:  acc_d = acc_q + 1'b1;
        OP_DEC:  acc_d = acc_q - 1'b1;
        OP_AND:  acc_d = acc_q & operand_i;
        OP_OR:   acc_d = acc_q | operand_i;
        OP_XOR:  acc_d = acc_q ^ operand_i;
        OP_CLR:  acc_d = '0;
        OP_CPL:  acc_d = ~acc_q;
        OP_RL:   acc_d = {acc_q[DW-2:0], acc_q[DW-1]};
        OP_RLC: begin
          acc_d = {acc_q[DW-2:0], cy_q};
          cy_d  = acc_q[DW-1];
        end
        OP_RR:   acc_d = {acc_q[0], acc_q[DW-1:1]};
        OP_RRC: begin
          acc_d = {cy_q, acc_q[DW-1:1]};
          cy_d  = acc_q[0];
        end
        OP_SWAP: acc_d = {acc_q[NW-1:0], acc_q[DW-1:NW]};
        OP_DA: begin
          acc_d = da_res;
          cy_d  = da_c;
        end
        OP_MUL, OP_DIV: begin
          cnt_d = CNT_W'(MD_CYCLES - 1);
          div_d = (op == OP_DIV);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      b_q   <= '0;
      cy_q  <= 1'b0;
      ac_q  <= 1'b0;
      ov_q  <= 1'b0;
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      b_q   <= b_d;
      cy_q  <= cy_d;
      ac_q  <= ac_d;
      ov_q  <= ov_d;
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign acc_o  = acc_q;
  assign b_o    = b_q;
  assign cy_o   = cy_q;
  assign ac_o   = ac_q;
  assign ov_o   = ov_q;
  assign par_o  = ^acc_q;
  assign busy_o = busy;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            op_valid_i,
  input logic [OP_W-1:0] op_i,
  input logic [DW-1:0]   operand_i,
  input logic [DW-1:0]   acc_o,
  input logic            cy_o,
  input logic            ac_o,
  input logic            ov_o,
  input logic            busy_o
);
  logic        take;
  logic [DW:0] sum_ext;

  assign take    = op_valid_i & ~busy_o;
  assign sum_ext = {1'b0, acc_o} + {1'b0, operand_i};

  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_i == OP_ADD) |=> cy_o == $past(sum_ext[DW])); // R1

  AST_STEP_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (op_i == OP_INC || op_i == OP_DEC)) |=> ($stable(cy_o) && $stable(ac_o) && $stable(ov_o))); // R3

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_i == OP_CLR) |=> acc_o == '0); // R4

  AST_SWAP_NIBBLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_i == OP_SWAP) |=> acc_o == {$past(acc_o[NW-1:0]), $past(acc_o[DW-1:NW])}); // R4

  AST_RLC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_i == OP_RLC) |=> cy_o == $past(acc_o[DW-1])); // R5

  AST_DA_CARRY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && op_i == OP_DA && cy_o) |=> cy_o); // R6

  AST_MD_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (op_i == OP_MUL || op_i == OP_DIV)) |=> busy_o); // R9

  AST_BUSY_HOLD_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(acc_o)); // R9

  AST_MD_AC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ac_o)); // R9
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .operand_i  (operand_i),
  .acc_o      (acc_o),
  .cy_o       (cy_o),
  .ac_o       (ac_o),
  .ov_o       (ov_o),
  .busy_o     (busy_o)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       op_valid_i = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic [7:0] acc_o, b_o;
  logic       cy_o, ac_o, ov_o, par_o, busy_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int a; int b; int c; int ac; int ov; string tag;
  } item_t;

  item_t mdl;
  item_t exp_q[$];
  event  chk_ev;

  always #2.5 clk_i = ~clk_i;

  acc_alu uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .operand_i(operand_i), .acc_o(acc_o), .b_o(b_o), .cy_o(cy_o),
    .ac_o(ac_o), .ov_o(ov_o), .par_o(par_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic item_t model(input item_t s, input int code, input int d);
    item_t r = s;
    int a = s.a;
    int t, sv, ci;
    case (code)
      1: r.a = d;
      2: r.b = d;
      3, 4: begin
        ci = (code == 4) ? s.c : 0;
        t = a + d + ci;
        r.a = t & 255; r.c = (t > 255);
        r.ac = (((a & 15) + (d & 15) + ci) > 15);
        sv = sx(a) + sx(d) + ci;
        r.ov = (sv > 127 || sv < -128);
      end
      5: begin
        t = a - d - s.c;
        r.a = t & 255; r.c = (t < 0);
        r.ac = (((a & 15) - (d & 15) - s.c) < 0);
        sv = sx(a) - sx(d) - s.c;
        r.ov = (sv > 127 || sv < -128);
      end
      6: r.a = (a + 1) & 255;
      7: r.a = (a + 255) & 255;
      8: r.a = a & d;
      9: r.a = a | d;
      10: r.a = a ^ d;
      11: r.a = 0;
      12: r.a = (~a) & 255;
      13: r.a = ((a << 1) | (a >> 7)) & 255;
      14: begin r.a = ((a << 1) | s.c) & 255; r.c = a >> 7; end
      15: r.a = (a >> 1) | ((a & 1) << 7);
      16: begin r.a = (a >> 1) | (s.c << 7); r.c = a & 1; end
      17: r.a = ((a & 15) << 4) | (a >> 4);
      18: begin
        t = a;
        if ((t & 15) > 9 || s.ac) t = t + 6;
        if (t > 255) r.c = 1;
        t = t & 255;
        if ((t >> 4) > 9 || r.c) t = t + 8'h60;
        if (t > 255) r.c = 1;
        r.a = t & 255;
      end
      19: begin
        t = a * s.b;
        r.a = t & 255; r.b = t >> 8; r.c = 0; r.ov = (t > 255);
      end
      20: begin
        r.c = 0;
        if (s.b == 0) r.ov = 1;
        else begin r.a = a / s.b; r.b = a % s.b; r.ov = 0; end
      end
      default: ;
    endcase
    return r;
  endfunction

  // Driver: applies one operation, queues the expected state, signals the monitor.
  task automatic run(input int code, input int d, input string tag, input bit inject = 0);
    item_t e;
    int n;
    @(negedge clk_i);
    op_valid_i = 1'b1; op_i = 5'(code); operand_i = 8'(d);
    e = model(mdl, code, d);
    e.tag = tag;
    mdl = e;
    exp_q.push_back(e);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    if (code == 19 || code == 20) begin
      n = 0;
      while (busy_o === 1'b1) begin
        n++;
        if (inject && n == 1) begin
          op_valid_i = 1'b1; op_i = 5'd1; operand_i = 8'h77;
        end else op_valid_i = 1'b0;
        @(negedge clk_i);
      end
      op_valid_i = 1'b0;
      chk(n == 3, "R9", {tag, " busy length"}, n, 3);
    end
    -> chk_ev;
  endtask

  // Monitor: compares the visible state with the queued expectation.
  initial begin
    item_t e;
    int p;
    forever begin
      @(chk_ev);
      e = exp_q.pop_front();
      p = ^(8'(e.a));
      chk(acc_o == 8'(e.a), e.tag, "A", acc_o, e.a);
      chk(b_o == 8'(e.b), e.tag, "B", b_o, e.b);
      chk(cy_o == e.c[0], e.tag, "C", cy_o, e.c);
      chk(ac_o == e.ac[0], e.tag, "AC", ac_o, e.ac);
      chk(ov_o == e.ov[0], e.tag, "OV", ov_o, e.ov);
      chk(par_o == p[0], "R10", {e.tag, " parity"}, par_o, p);
      chk(busy_o == 1'b0, e.tag, "busy", busy_o, 0);
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired before the sequence completed");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    mdl = '{a: 0, b: 0, c: 0, ac: 0, ov: 0, tag: "R11 reset"};
    repeat (3) @(negedge clk_i);
    exp_q.push_back(mdl);
    -> chk_ev;
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 additions
    run(1, 8'h3A, "R4 lda");
    run(3, 8'h46, "R1 add nibble+sign");
    run(3, 8'hFF, "R1 add carry");
    run(4, 8'h01, "R1 addc with C");
    run(4, 8'h7F, "R1 addc overflow");
    // R2 subtractions
    run(5, 8'h05, "R2 subb");
    run(1, 8'h00, "R4 lda zero");
    run(5, 8'h01, "R2 subb borrow");
    run(5, 8'h80, "R2 subb with C");
    run(1, 8'h80, "R4 lda");
    run(5, 8'h01, "R2 subb signed ovf");
    // R3 step
    run(1, 8'hFF, "R4 lda");
    run(3, 8'h01, "R1 add sets C AC");
    run(7, 0, "R3 dec wrap keeps flags");
    run(6, 0, "R3 inc wrap keeps flags");
    run(6, 0, "R3 inc");
    // R4 logic
    run(1, 8'hA5, "R4 lda");
    run(8, 8'h3C, "R4 and");
    run(9, 8'h81, "R4 or");
    run(10, 8'hFF, "R4 xor");
    run(12, 0, "R4 cpl");
    run(17, 0, "R4 swap");
    run(0, 8'h12, "R4 nop");
    run(25, 8'h12, "R4 unused code");
    run(11, 0, "R4 clr");
    // R5 rotates
    run(1, 8'h81, "R4 lda");
    run(13, 0, "R5 rl");
    run(15, 0, "R5 rr");
    run(14, 0, "R5 rlc");
    run(14, 0, "R5 rlc again");
    run(16, 0, "R5 rrc");
    run(16, 0, "R5 rrc again");
    // R6 decimal adjust
    run(1, 8'h12, "R4 lda");
    run(3, 8'h34, "R1 bcd add");
    run(18, 0, "R6 da no fix");
    run(1, 8'h49, "R4 lda");
    run(3, 8'h38, "R1 bcd add");
    run(18, 0, "R6 da low fix");
    run(1, 8'h99, "R4 lda");
    run(3, 8'h99, "R1 bcd add");
    run(18, 0, "R6 da both fix");
    run(1, 8'h9A, "R4 lda");
    run(18, 0, "R6 da carry out");
    run(1, 8'h05, "R4 lda");
    run(18, 0, "R6 da C forced high fix");
    // R7 multiply
    run(1, 8'h50, "R4 lda");
    run(2, 8'hA0, "R4 ldb");
    run(19, 0, "R7 mul wide");
    run(1, 8'h03, "R4 lda");
    run(2, 8'h04, "R4 ldb");
    run(19, 0, "R7 mul narrow", 1'b1);
    // R8 divide
    run(1, 8'hFB, "R4 lda");
    run(2, 8'h12, "R4 ldb");
    run(20, 0, "R8 div");
    run(2, 8'h00, "R4 ldb zero");
    run(20, 0, "R8 div by zero", 1'b1);
    run(2, 8'h07, "R4 ldb");
    run(20, 0, "R8 div clears OV");
    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule